// File: doc/BRIEF.md
# Console Bus Region Decoder with Access Timing

This block sits between a processor core and the memory system of a game console. It takes a 24-bit address, split into an 8-bit bank and a 16-bit offset, and turns it into one device select. The targets are work RAM, the cartridge, the 8-bit secondary peripheral bus or the internal register file. For the secondary bus it also drives the low address byte and decodes which peripheral group the byte falls in.

Each accepted access runs for a fixed number of master-clock cycles, and that number depends on the region: 6 for fast, 8 for slow and 12 for extra-slow. The upper cartridge area can be switched to the fast speed by a one-bit enable. Software sets that bit by writing to a control address. The block raises a one-clock completion pulse when the access ends.

A data holder keeps the last value that crossed the data bus. A read that no device answers therefore returns that value.

Top module: `bus_region_decoder`

## Requirements
- R1: After reset, every select, `bbus_addr_o`, `done_o` and `rd_data_o` are 0, and the fast-cartridge enable is 0.
- R2: Work RAM select covers all offsets of banks $7E-$7F. It also covers offsets $0000-$1FFF in the system banks ($00-$3F, $80-$BF). Both areas take 8 cycles.
- R3: System-bank offsets $2100-$21FF assert the secondary-bus select and drive offset bits [7:0] on `bbus_addr_o`. These accesses take 6 cycles.
- R4: Within a secondary-bus access, a low byte of $00-$3F raises `ppu_sel_o`, $40-$7F raises `apu_sel_o` and $80-$83 raises `wport_sel_o`. Any other low byte raises none of the three.
- R5: System-bank offsets $4000-$41FF assert the internal-register select for 12 cycles. Offsets $4200-$43FF assert it for 6 cycles.
- R6: The cartridge select covers offsets $8000-$FFFF of banks $00-$3F and all offsets of banks $40-$7D, both at 8 cycles. It also covers offsets $8000-$FFFF of banks $80-$BF and all offsets of banks $C0-$FF.
- R7: The cartridge areas of banks $80-$BF and $C0-$FF take 6 cycles when the fast enable is 1 and 8 cycles when it is 0. A completed write to offset $420D in a system bank loads the enable from data bit 0. The new value applies to later accesses.
- R8: The system-bank offsets $2000-$20FF, $2200-$3FFF and $4400-$5FFF take 6 cycles, and $6000-$7FFF take 8 cycles. None of these assert a select.
- R9: An internal cycle (`int_cyc_i` high) takes 6 cycles whatever the address. It asserts no select and leaves `rd_data_o` unchanged.
- R10: An access is accepted at the rising edge where `req_i` is high and no access is in progress. Its selects stay valid until the edge that ends the access. `done_o` is high for exactly the N-th clock after acceptance, where N is the cycle count. A request made while an access is in progress is ignored.
- R11: At the end of a non-internal access, `rd_data_o` takes the write data of a write, or `rdata_i` of a read with `rvalid_i` high. A read with `rvalid_i` low leaves `rd_data_o` holding the last bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| bank_i | input | 8 | Address bank |
| offs_i | input | 16 | Address offset within bank |
| wr_i | input | 1 | 1 = write, 0 = read |
| int_cyc_i | input | 1 | Internal cycle, no bus transfer |
| wdata_i | input | DATA_W | Write data, sampled at acceptance |
| rvalid_i | input | 1 | A device answered the read, sampled at the ending edge |
| rdata_i | input | DATA_W | Read data from the answering device |
| wram_sel_o | output | 1 | Work RAM select |
| cart_sel_o | output | 1 | Cartridge select |
| bbus_sel_o | output | 1 | Secondary bus select |
| bbus_addr_o | output | 8 | Secondary bus address |
| ireg_sel_o | output | 1 | Internal register select |
| ppu_sel_o | output | 1 | Picture-unit group on secondary bus |
| apu_sel_o | output | 1 | Audio-unit group on secondary bus |
| wport_sel_o | output | 1 | Work-RAM port group on secondary bus |
| done_o | output | 1 | One-clock completion pulse |
| rd_data_o | output | DATA_W | Last value seen on the data bus |

## Verification
Selects and the secondary address appear in the first clock after the accepting edge. `done_o` is due in the N-th clock after that edge. `rd_data_o` and the fast enable change only on the edge that closes the `done_o` clock.

The bench drives inputs on falling edges and compares every output with a behavioural model on each falling edge. The model advances on the rising edge, exactly as the design does.

Directed checks count falling edges from acceptance up to `done_o`. They capture the selects in the first clock, and read `rd_data_o` one clock after `done_o`. The fast-enable change is observed only through the cycle count of the next cartridge access.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  localparam int BANK_W = 8;
  localparam int OFFS_W = 16;
  localparam int SUB_W  = 8;

  typedef enum logic [1:0] {
    SPD_FAST  = 2'd0,
    SPD_SLOW  = 2'd1,
    SPD_XSLOW = 2'd2,
    SPD_ROM   = 2'd3   // fast or slow by the enable bit
  } spd_e;

  typedef struct packed {
    logic wram;
    logic cart;
    logic bbus;
    logic ireg;
    logic ppu;
    logic apu;
    logic wport;
  } sel_t;

  typedef struct packed {
    sel_t sel;
    spd_e spd;
  } dec_t;
endpackage

// File: rtl/bus_region_map.sv
module bus_region_map
  import bus_dec_pkg::*;
(
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFFS_W-1:0] offs_i,
  output dec_t              dec_o
);
  logic sys_bank, hi_bank, wram_bank, sub_hit;
  logic [SUB_W-1:0] sub_addr;

  assign sys_bank  = ~bank_i[6];
  assign hi_bank   = bank_i[7];
  assign wram_bank = (bank_i[7:1] == 7'h3F);
  assign sub_addr  = offs_i[SUB_W-1:0];
  assign sub_hit   = sys_bank & (offs_i[15:8] == 8'h21);

  always_comb begin
    dec_o     = '0;
    dec_o.spd = SPD_SLOW;
    if (sys_bank) begin
      if (offs_i[15]) begin
        dec_o.sel.cart = 1'b1;
        dec_o.spd      = hi_bank ? SPD_ROM : SPD_SLOW;
      end else begin
        unique case (offs_i[14:13])
          2'b00: dec_o.sel.wram = 1'b1;
          2'b01: begin
            dec_o.spd      = SPD_FAST;
            dec_o.sel.bbus = sub_hit;
          end
          2'b10: begin
            if (offs_i[12:10] == 3'b000) begin
              dec_o.sel.ireg = 1'b1;
              dec_o.spd      = offs_i[9] ? SPD_FAST : SPD_XSLOW;
            end else begin
              dec_o.spd = SPD_FAST;
            end
          end
          default: dec_o.spd = SPD_SLOW;
        endcase
      end
    end else if (wram_bank) begin
      dec_o.sel.wram = 1'b1;
    end else begin
      dec_o.sel.cart = 1'b1;
      dec_o.spd      = hi_bank ? SPD_ROM : SPD_SLOW;
    end
    if (sub_hit) begin
      dec_o.sel.ppu   = (sub_addr[7:6] == 2'b00);
      dec_o.sel.apu   = (sub_addr[7:6] == 2'b01);
      dec_o.sel.wport = (sub_addr[7:2] == 6'b100000);
    end
  end
endmodule

// File: rtl/bus_access_timer.sv
module bus_access_timer
  import bus_dec_pkg::*;
#(
  parameter int CYC_FAST  = 6,
  parameter int CYC_SLOW  = 8,
  parameter int CYC_XSLOW = 12,
  parameter int CYC_INT   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  spd_e spd_i,
  input  logic rom_fast_i,
  input  logic int_i,
  output logic busy_o,
  output logic last_o
);
  localparam int MAX_A   = (CYC_FAST > CYC_SLOW) ? CYC_FAST : CYC_SLOW;
  localparam int MAX_B   = (CYC_XSLOW > CYC_INT) ? CYC_XSLOW : CYC_INT;
  localparam int CYC_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  logic [CNT_W-1:0] cnt_q, load;

  always_comb begin
    if (int_i) begin
      load = CNT_W'(CYC_INT);
    end else begin
      unique case (spd_i)
        SPD_FAST:  load = CNT_W'(CYC_FAST);
        SPD_XSLOW: load = CNT_W'(CYC_XSLOW);
        SPD_ROM:   load = rom_fast_i ? CNT_W'(CYC_FAST) : CNT_W'(CYC_SLOW);
        default:   load = CNT_W'(CYC_SLOW);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= load;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/bus_open_latch.sv
module bus_open_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic              int_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (end_i && !int_i) begin
      if (wr_i)          q_o <= wdata_i;
      else if (rvalid_i) q_o <= rdata_i;
    end
  end
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import bus_dec_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CYC_FAST  = 6,
  parameter int CYC_SLOW  = 8,
  parameter int CYC_XSLOW = 12,
  parameter int CYC_INT   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        bank_i,
  input  logic [15:0]       offs_i,
  input  logic              wr_i,
  input  logic              int_cyc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wram_sel_o,
  output logic              cart_sel_o,
  output logic              bbus_sel_o,
  output logic [7:0]        bbus_addr_o,
  output logic              ireg_sel_o,
  output logic              ppu_sel_o,
  output logic              apu_sel_o,
  output logic              wport_sel_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [OFFS_W-1:0] CTL_OFFS = 16'h420D;

  dec_t              dec_n;
  sel_t              sel_q, sel_act;
  logic [SUB_W-1:0]  sub_q;
  logic              wr_q, int_q, ctl_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rom_fast_q;
  logic              busy, last, accept, ctl_hit;

  bus_region_map u_map (
    .bank_i (bank_i),
    .offs_i (offs_i),
    .dec_o  (dec_n)
  );

  assign accept  = req_i & ~busy;
  assign ctl_hit = ~bank_i[6] & (offs_i == CTL_OFFS);

  bus_access_timer #(
    .CYC_FAST  (CYC_FAST),
    .CYC_SLOW  (CYC_SLOW),
    .CYC_XSLOW (CYC_XSLOW),
    .CYC_INT   (CYC_INT)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .spd_i      (dec_n.spd),
    .rom_fast_i (rom_fast_q),
    .int_i      (int_cyc_i),
    .busy_o     (busy),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      sub_q   <= '0;
      wr_q    <= 1'b0;
      int_q   <= 1'b0;
      ctl_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      sel_q   <= int_cyc_i ? '0 : dec_n.sel;
      sub_q   <= offs_i[SUB_W-1:0];
      wr_q    <= wr_i;
      int_q   <= int_cyc_i;
      ctl_q   <= ctl_hit;
      wdata_q <= wdata_i;
    end
  end

  // enable changes at the closing edge, so it cannot affect the access in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              rom_fast_q <= 1'b0;
    else if (last && wr_q && !int_q && ctl_q) rom_fast_q <= wdata_q[0];
  end

  bus_open_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .end_i    (last),
    .int_i    (int_q),
    .wr_i     (wr_q),
    .wdata_i  (wdata_q),
    .rvalid_i (rvalid_i),
    .rdata_i  (rdata_i),
    .q_o      (rd_data_o)
  );

  assign sel_act     = busy ? sel_q : '0;
  assign wram_sel_o  = sel_act.wram;
  assign cart_sel_o  = sel_act.cart;
  assign bbus_sel_o  = sel_act.bbus;
  assign ireg_sel_o  = sel_act.ireg;
  assign ppu_sel_o   = sel_act.ppu;
  assign apu_sel_o   = sel_act.apu;
  assign wport_sel_o = sel_act.wport;
  assign bbus_addr_o = sel_act.bbus ? sub_q : '0;
  assign done_o      = last;
endmodule

// File: rtl/bus_region_decoder_chk.sv
module bus_region_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wram_sel_o,
  input logic              cart_sel_o,
  input logic              bbus_sel_o,
  input logic [7:0]        bbus_addr_o,
  input logic              ireg_sel_o,
  input logic              ppu_sel_o,
  input logic              apu_sel_o,
  input logic              wport_sel_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rd_data_o
);
  logic [3:0] main_sel;
  logic [2:0] sub_sel;
  assign main_sel = {wram_sel_o, cart_sel_o, bbus_sel_o, ireg_sel_o};
  assign sub_sel  = {ppu_sel_o, apu_sel_o, wport_sel_o};

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_sel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(main_sel));

  a_r10_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((main_sel != 4'b0) && !done_o) |=> $stable(main_sel));

  a_r10_sel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (main_sel == 4'b0));

  a_r4_sub_in_bbus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_sel != 3'b0) |-> bbus_sel_o);

  a_r4_sub_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sub_sel));

  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bbus_sel_o && !done_o) |=> (bbus_sel_o && $stable(bbus_addr_o)));

  a_r11_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(rd_data_o));
endmodule

bind bus_region_decoder bus_region_decoder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bus_region_decoder_tb.sv
module bus_region_decoder_tb;
  localparam time TCK = 8ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       req_i = 1'b0, wr_i = 1'b0, int_cyc_i = 1'b0, rvalid_i = 1'b0;
  logic [7:0] bank_i = '0, wdata_i = '0, rdata_i = '0;
  logic [15:0] offs_i = '0;
  logic       wram_sel_o, cart_sel_o, bbus_sel_o, ireg_sel_o;
  logic       ppu_sel_o, apu_sel_o, wport_sel_o, done_o;
  logic [7:0] bbus_addr_o, rd_data_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(TCK/2) clk_i = ~clk_i;

  bus_region_decoder u_dut (.*);

  // sel order {wram,cart,bbus,ireg,ppu,apu,wport}
  function automatic logic [6:0] act_sel();
    return {wram_sel_o, cart_sel_o, bbus_sel_o, ireg_sel_o, ppu_sel_o, apu_sel_o, wport_sel_o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  function automatic void ref_decode(input int b, input int o, input bit ic, input bit fe,
                                     output int cyc, output logic [6:0] sel);
    bit sys = (b <= 'h3F) || (b >= 'h80 && b <= 'hBF);
    int lo = o % 256;
    sel = '0;
    cyc = 8;
    if (ic) cyc = 6;
    else if (sys && o <= 'h1FFF) sel = 7'b1000000;
    else if (sys && o >= 'h2100 && o <= 'h21FF) begin
      cyc = 6;
      sel = 7'b0010000;
      if (lo < 'h40) sel[2] = 1'b1;
      else if (lo < 'h80) sel[1] = 1'b1;
      else if (lo <= 'h83) sel[0] = 1'b1;
    end
    else if (sys && o >= 'h4000 && o <= 'h41FF) begin cyc = 12; sel = 7'b0001000; end
    else if (sys && o >= 'h4200 && o <= 'h43FF) begin cyc = 6; sel = 7'b0001000; end
    else if (sys && o >= 'h2000 && o <= 'h5FFF) cyc = 6;
    else if (sys && o <= 'h7FFF) cyc = 8;
    else if (sys) begin sel = 7'b0100000; cyc = (b >= 'h80 && fe) ? 6 : 8; end
    else if (b == 'h7E || b == 'h7F) sel = 7'b1000000;
    else begin sel = 7'b0100000; cyc = (b >= 'hC0 && fe) ? 6 : 8; end
  endfunction

  int m_cnt = 0;
  bit m_fe = 0, m_wr = 0, m_ic = 0, m_ctl = 0;
  logic [6:0] m_sel = '0;
  logic [7:0] m_sub = '0, m_wd = '0, m_bus = '0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_fe = 0; m_bus = '0;
    end else if (m_cnt == 0) begin
      if (req_i) begin
        int c;
        logic [6:0] s;
        ref_decode(bank_i, offs_i, int_cyc_i, m_fe, c, s);
        m_cnt = c; m_sel = s; m_sub = offs_i[7:0];
        m_wr = wr_i; m_ic = int_cyc_i; m_wd = wdata_i;
        m_ctl = ((bank_i <= 8'h3F) || (bank_i >= 8'h80 && bank_i <= 8'hBF)) && offs_i == 16'h420D;
      end
    end else begin
      if (m_cnt == 1 && !m_ic) begin
        if (m_wr) begin
          m_bus = m_wd;
          if (m_ctl) m_fe = m_wd[0];
        end else if (rvalid_i) m_bus = rdata_i;
      end
      m_cnt--;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk("R10 model done",   {31'b0, done_o}, {31'b0, m_cnt == 1});
      chk("R2 model wram",    {31'b0, wram_sel_o}, {31'b0, m_cnt != 0 && m_sel[6]});
      chk("R6 model cart",    {31'b0, cart_sel_o}, {31'b0, m_cnt != 0 && m_sel[5]});
      chk("R3 model bbus",    {31'b0, bbus_sel_o}, {31'b0, m_cnt != 0 && m_sel[4]});
      chk("R5 model ireg",    {31'b0, ireg_sel_o}, {31'b0, m_cnt != 0 && m_sel[3]});
      chk("R4 model sub",     {29'b0, ppu_sel_o, apu_sel_o, wport_sel_o},
                              {29'b0, (m_cnt != 0) ? m_sel[2:0] : 3'b0});
      chk("R3 model addr",    {24'b0, bbus_addr_o}, {24'b0, (m_cnt != 0 && m_sel[4]) ? m_sub : 8'h00});
      chk("R11 model data",   {24'b0, rd_data_o}, {24'b0, m_bus});
    end
  end

  logic [6:0] obs_sel;
  logic [7:0] obs_addr;

  task automatic access(input logic [7:0] b, input logic [15:0] o, input bit w, input bit ic,
                        input logic [7:0] wd, input bit rv, input logic [7:0] rd,
                        input int exp_cyc, input logic [6:0] exp_sel, input string tag);
    int n;
    @(negedge clk_i);
    bank_i = b; offs_i = o; wr_i = w; int_cyc_i = ic; wdata_i = wd;
    rvalid_i = rv; rdata_i = rd; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    n = 1;
    obs_sel = act_sel();
    obs_addr = bbus_addr_o;
    while (!done_o && n < 40) begin
      @(negedge clk_i);
      n++;
    end
    chk({tag, " cycles"}, n, exp_cyc);
    chk({tag, " sel"}, {25'b0, obs_sel}, {25'b0, exp_sel});
    @(negedge clk_i);
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(TCK * 3);
    chk("R1 reset sel", {25'b0, act_sel()}, 32'h0);
    chk("R1 reset done", {31'b0, done_o}, 32'h0);
    chk("R1 reset data", {24'b0, rd_data_o}, 32'h0);
    chk("R1 reset addr", {24'b0, bbus_addr_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 / R7: enable is 0 after reset, upper cartridge is slow
    access(8'hC0, 16'h0000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R1 R7 rom slow at reset");
    // R2
    access(8'h00, 16'h1234, 0, 0, 8'h00, 0, 8'h00, 8, 7'b1000000, "R2 low mirror");
    access(8'h7E, 16'h8000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b1000000, "R2 bank 7E");
    access(8'h7F, 16'hFFFF, 0, 0, 8'h00, 0, 8'h00, 8, 7'b1000000, "R2 bank 7F");
    access(8'hBF, 16'h1FFF, 0, 0, 8'h00, 0, 8'h00, 8, 7'b1000000, "R2 high mirror");
    // R3 / R4
    access(8'h00, 16'h2118, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0010100, "R3 R4 ppu");
    chk("R3 addr", {24'b0, obs_addr}, 32'h18);
    access(8'h80, 16'h2140, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0010010, "R4 apu");
    access(8'h3F, 16'h2183, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0010001, "R4 wport");
    access(8'h00, 16'h2184, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0010000, "R4 none");
    chk("R3 addr high", {24'b0, obs_addr}, 32'h84);
    // R5
    access(8'h00, 16'h4016, 0, 0, 8'h00, 0, 8'h00, 12, 7'b0001000, "R5 xslow");
    access(8'h80, 16'h41FF, 0, 0, 8'h00, 0, 8'h00, 12, 7'b0001000, "R5 xslow top");
    access(8'h00, 16'h4200, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0001000, "R5 fast");
    // R6
    access(8'h00, 16'h8000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R6 low bank");
    access(8'h40, 16'h0000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R6 bank 40");
    access(8'h7D, 16'hFFFF, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R6 bank 7D");
    // R8
    access(8'h00, 16'h2000, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0000000, "R8 2000");
    access(8'h80, 16'h3000, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0000000, "R8 3000");
    access(8'h00, 16'h5000, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0000000, "R8 5000");
    access(8'h00, 16'h6000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0000000, "R8 6000");
    // R7
    access(8'h80, 16'h8000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R7 80 slow");
    access(8'h00, 16'h420D, 1, 0, 8'h01, 0, 8'h00, 6, 7'b0001000, "R7 enable write");
    access(8'hC0, 16'h0000, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0100000, "R7 C0 fast");
    access(8'h80, 16'h8000, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0100000, "R7 80 fast");
    access(8'h00, 16'h8000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R7 low bank stays slow");
    access(8'h80, 16'h7FFF, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0000000, "R7 R8 6000 area unaffected");
    access(8'h40, 16'h420D, 1, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R7 non-system write");
    access(8'hFF, 16'hFFFF, 0, 0, 8'h00, 0, 8'h00, 6, 7'b0100000, "R7 still fast");
    access(8'h80, 16'h420D, 1, 0, 8'hFE, 0, 8'h00, 6, 7'b0001000, "R7 enable clear");
    access(8'hC0, 16'h0000, 0, 0, 8'h00, 0, 8'h00, 8, 7'b0100000, "R7 C0 slow again");
    // R11
    access(8'h00, 16'h0000, 1, 0, 8'hA5, 0, 8'h00, 8, 7'b1000000, "R11 write");
    chk("R11 write data", {24'b0, rd_data_o}, 32'hA5);
    access(8'h7E, 16'h0010, 0, 0, 8'h00, 1, 8'h3C, 8, 7'b1000000, "R11 answered read");
    chk("R11 read data", {24'b0, rd_data_o}, 32'h3C);
    access(8'h00, 16'h2000, 0, 0, 8'h00, 0, 8'h77, 6, 7'b0000000, "R11 open read");
    chk("R11 open bus", {24'b0, rd_data_o}, 32'h3C);
    // R9
    access(8'h7E, 16'h0000, 1, 1, 8'h99, 1, 8'h55, 6, 7'b0000000, "R9 internal");
    chk("R9 data kept", {24'b0, rd_data_o}, 32'h3C);
    access(8'h00, 16'h4000, 0, 1, 8'h00, 0, 8'h00, 6, 7'b0000000, "R9 internal xslow addr");

    // R10: request during a busy access is ignored
    begin
      int n, extra;
      @(negedge clk_i);
      bank_i = 8'h00; offs_i = 16'h4000; wr_i = 0; int_cyc_i = 0; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0; n = 1;
      @(negedge clk_i); n++;
      bank_i = 8'h7E; offs_i = 16'h0000; req_i = 1'b1;
      @(negedge clk_i); n++;
      req_i = 1'b0;
      while (!done_o && n < 40) begin @(negedge clk_i); n++; end
      chk("R10 busy length", n, 12);
      extra = 0;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk_i);
        if (done_o || act_sel() != 7'b0) extra++;
      end
      chk("R10 ignored request", extra, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule